// File: doc/BRIEF.md
# NAND cache read pipeline engine

This block is the device-side control for a pipelined page read in a NAND flash store. A host sends commands over a single-cycle command strobe. Each command carries an 8-bit code and, when one is supplied, a page address. A plain read brings one page from a modelled flash array into an internal data register. A cache-read continue command then moves that page into an output page register and starts fetching the following page in the background. A terminate command moves the last fetched page across and starts no further fetch.

The host drains the page register one byte per read strobe while the next array fetch runs. Because the fetch takes far fewer cycles than a full drain, the fetch stays hidden behind the output. A ready bit shows when the engine accepts a command. A sticky error bit records every command that was refused. Latencies and sizes are cycle-count parameters, so the behaviour can be exercised quickly.

Top module: `nand_cache_reader`

## Requirements
- R1: After reset, ready is 1 and err is 0. With no page loaded, rd_data reads 0xFF.
- R2: The modelled array byte at page p, column c is (3*p + 5*c + 0x5A) mod 256. Command code 0x30 with page p is accepted when the engine is idle or holds a terminated page. It drops ready for FETCH_CYCLES+1 cycles. Afterwards the engine is idle with page p in the data register, and rd_data still reads 0xFF until a page is copied.
- R3: Code 0x31, accepted after a completed read, drops ready for exactly one copy cycle. After that cycle the page register holds the page last fetched. A fetch of the next page then starts, while ready stays 1.
- R4: A 0x31 with cmd_addr_valid=0 fetches the page after the most recently started fetch. A 0x31 with cmd_addr_valid=1 fetches cmd_page.
- R5: A 0x31 or 0x3F that arrives while a background fetch is still running keeps ready low until that fetch ends, and for one copy cycle after it.
- R6: Code 0x3F, accepted after a completed read or during cache reading, copies the last fetched page and starts no fetch. After it, 0x31 and 0x3F are refused until a new 0x30.
- R7: Each rd_strobe in a ready state advances the column. Past the last byte of the page, rd_data reads 0xFF and the column does not wrap. A strobe while ready is 0 has no effect.
- R8: A 0x31 without an address, when the most recently started fetch was for the last page (all ones), sets err. The engine stays ready and keeps its page register contents.
- R9: A command is refused and sets err when ready is 0, when it is out of place, or when its code is not 0x30, 0x31 or 0x3F. A 0x31 or 0x3F is out of place when no read has completed first. err stays set until reset.
- R10: Each copy into the page register restarts output at column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 8 | Command code (0x30 read, 0x31 continue, 0x3F terminate) |
| cmd_addr_valid | input | 1 | cmd_page is supplied with a 0x31 |
| cmd_page | input | PAGE_BITS | Page address |
| rd_strobe | input | 1 | Advance the output column by one byte |
| rd_data | output | 8 | Byte at the current column of the page register |
| ready | output | 1 | Engine accepts commands |
| err | output | 1 | Sticky refused-command flag |

## Verification
The bench first checks a continue issued while the background fetch is still running. A design that copied early would hand out a stale page, and one that never waited would raise ready too soon. It also checks sequential continues at the top page and commands sent while busy. A faulty engine there would wrap to page 0 or corrupt its state instead of flagging an error.

Reads past the end of a page must return 0xFF rather than wrap to byte 0, and every copy must restart at column 0. A design that carried the old column would start the next page mid-way. Finally, after a terminate no further fetch may start, so a later continue must be refused.

// File: rtl/nand_cache_reader.sv
module nand_cache_reader #(
  parameter int PAGE_BYTES   = 64,
  parameter int PAGE_BITS    = 6,
  parameter int FETCH_CYCLES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [7:0]           cmd_code,
  input  logic                 cmd_addr_valid,
  input  logic [PAGE_BITS-1:0] cmd_page,
  input  logic                 rd_strobe,
  output logic [7:0]           rd_data,
  output logic                 ready,
  output logic                 err
);
  localparam int IDX_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
  localparam int COL_W = $clog2(PAGE_BYTES + 1);
  localparam int CNT_W = $clog2(FETCH_CYCLES + 1);
  localparam logic [COL_W-1:0]     COL_END   = COL_W'(PAGE_BYTES);
  localparam logic [CNT_W-1:0]     FCNT_INIT = CNT_W'(FETCH_CYCLES - 1);
  localparam logic [PAGE_BITS-1:0] LAST_PAGE = {PAGE_BITS{1'b1}};
  localparam logic [7:0] CMD_READ = 8'h30;
  localparam logic [7:0] CMD_CONT = 8'h31;
  localparam logic [7:0] CMD_TERM = 8'h3F;

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_COPY, ST_CACHE, ST_LAST} state_t;
  typedef enum logic [1:0] {P_READ, P_CONT, P_TERM} pend_t;

  state_t state;
  pend_t  pend;
  logic                        fetching, dvalid, pvalid;
  logic [CNT_W-1:0]            fcnt;
  logic [PAGE_BITS-1:0]        fpage, target;
  logic [COL_W-1:0]            col;
  logic [PAGE_BYTES-1:0][7:0]  dreg, preg;

  function automatic logic [7:0] array_byte(input logic [PAGE_BITS-1:0] p, input int c);
    logic [31:0] v;
    v = 32'(p) * 32'd3 + 32'(c) * 32'd5 + 32'h5A;
    return v[7:0];
  endfunction

  assign ready = (state == ST_IDLE) || (state == ST_CACHE) || (state == ST_LAST);

  logic can_cache, accept_read, accept_cont, accept_term, bad_cmd;
  assign can_cache   = ((state == ST_IDLE) && dvalid) || (state == ST_CACHE);
  assign accept_read = ready && cmd_valid && (cmd_code == CMD_READ) && (state != ST_CACHE);
  assign accept_cont = ready && cmd_valid && (cmd_code == CMD_CONT) && can_cache &&
                       (cmd_addr_valid || (fpage != LAST_PAGE));
  assign accept_term = ready && cmd_valid && (cmd_code == CMD_TERM) && can_cache;
  assign bad_cmd     = cmd_valid && !(accept_read || accept_cont || accept_term);

  assign rd_data = (pvalid && (col < COL_END)) ? preg[col[IDX_W-1:0]] : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pend     <= P_READ;
      fetching <= 1'b0;
      dvalid   <= 1'b0;
      pvalid   <= 1'b0;
      fcnt     <= '0;
      fpage    <= '0;
      target   <= '0;
      col      <= '0;
      err      <= 1'b0;
      dreg     <= '0;
      preg     <= '0;
    end else begin
      if (fetching) begin
        if (fcnt == '0) begin
          fetching <= 1'b0;
          dvalid   <= 1'b1;
          for (int i = 0; i < PAGE_BYTES; i++) dreg[i] <= array_byte(fpage, i);
        end else begin
          fcnt <= fcnt - 1'b1;
        end
      end

      if (bad_cmd) err <= 1'b1;

      if (ready && rd_strobe && (col < COL_END)) col <= col + 1'b1;

      case (state)
        ST_IDLE, ST_CACHE, ST_LAST: begin
          if (accept_read) begin
            fetching <= 1'b1;
            fcnt     <= FCNT_INIT;
            fpage    <= cmd_page;
            pend     <= P_READ;
            pvalid   <= 1'b0;
            dvalid   <= 1'b0;
            state    <= ST_FETCH;
          end else if (accept_cont || accept_term) begin
            pend   <= accept_cont ? P_CONT : P_TERM;
            target <= cmd_addr_valid ? cmd_page : fpage + PAGE_BITS'(1);
            state  <= fetching ? ST_FETCH : ST_COPY;
          end
        end
        ST_FETCH: begin
          if (!fetching) state <= (pend == P_READ) ? ST_IDLE : ST_COPY;
        end
        ST_COPY: begin
          preg   <= dreg;
          pvalid <= 1'b1;
          col    <= '0;
          dvalid <= 1'b0;
          if (pend == P_CONT) begin
            fetching <= 1'b1;
            fcnt     <= FCNT_INIT;
            fpage    <= target;
            state    <= ST_CACHE;
          end else begin
            state <= ST_LAST;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: busy command is refused and flagged
  a_r9_busy_cmd_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !ready) |=> err);

  // R9: flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R8: sequential continue at the top page leaves the engine as it was
  a_r8_top_page_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd_valid && (cmd_code == CMD_CONT) && !cmd_addr_valid && (fpage == LAST_PAGE))
    |=> (err && $stable(state) && ready));

  // R6: terminated engine runs no fetch
  a_r6_no_fetch_after_term: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LAST) |-> !fetching);

  // R10: output restarts at byte 0 of the copied page
  a_r10_copy_starts_col0: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COPY) |=> (rd_data == $past(dreg[0])));

  // R3: copy occupies a single busy cycle
  a_r3_copy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COPY) |=> ready);
endmodule

// File: tb/nand_cache_reader_tb.sv
`timescale 1ns/1ps
module nand_cache_reader_tb;
  localparam int PB = 64;
  localparam int PBITS = 6;
  localparam int FC = 16;
  localparam int LASTP = (1 << PBITS) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic cmd_addr_valid = 1'b0;
  logic [PBITS-1:0] cmd_page = '0;
  logic rd_strobe = 1'b0;
  logic [7:0] rd_data;
  logic ready, err;

  always #2.5 clk = ~clk;

  nand_cache_reader #(.PAGE_BYTES(PB), .PAGE_BITS(PBITS), .FETCH_CYCLES(FC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr_valid(cmd_addr_valid), .cmd_page(cmd_page), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .ready(ready), .err(err));

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  function automatic int abyte(int p, int c);
    return (3 * p + 5 * c + 90) % 256;
  endfunction

  // behavioural reference: states 0 idle,1 fetch,2 copy,3 cache,4 last
  int m_state, m_fcnt, m_fpage, m_dpage, m_ppage, m_col, m_pend, m_target;
  bit m_fetching, m_dvalid, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_fcnt = 0; m_fpage = 0; m_dpage = -1; m_ppage = -1;
      m_col = 0; m_pend = 0; m_target = 0; m_fetching = 0; m_dvalid = 0; m_err = 0;
    end else begin
      int n_state, n_fcnt, n_fpage, n_dpage, n_ppage, n_col, n_pend, n_target;
      bit n_fetching, n_dvalid, n_err, rdy, cc;
      n_state = m_state; n_fcnt = m_fcnt; n_fpage = m_fpage; n_dpage = m_dpage;
      n_ppage = m_ppage; n_col = m_col; n_pend = m_pend; n_target = m_target;
      n_fetching = m_fetching; n_dvalid = m_dvalid; n_err = m_err;
      rdy = (m_state == 0) || (m_state == 3) || (m_state == 4);
      cc = ((m_state == 0) && m_dvalid) || (m_state == 3);
      if (m_fetching) begin
        if (m_fcnt == 0) begin n_fetching = 0; n_dpage = m_fpage; n_dvalid = 1; end
        else n_fcnt = m_fcnt - 1;
      end
      if (rdy && rd_strobe && m_col < PB) n_col = m_col + 1;
      if (rdy) begin
        if (cmd_valid) begin
          if (cmd_code == 8'h30 && m_state != 3) begin
            n_fetching = 1; n_fcnt = FC - 1; n_fpage = cmd_page; n_pend = 0;
            n_ppage = -1; n_dvalid = 0; n_state = 1;
          end else if (cmd_code == 8'h31 && cc && (cmd_addr_valid || m_fpage != LASTP)) begin
            n_pend = 1; n_target = cmd_addr_valid ? int'(cmd_page) : m_fpage + 1;
            n_state = m_fetching ? 1 : 2;
          end else if (cmd_code == 8'h3F && cc) begin
            n_pend = 2; n_state = m_fetching ? 1 : 2;
          end else n_err = 1;
        end
      end else begin
        if (cmd_valid) n_err = 1;
        if (m_state == 1) begin
          if (!m_fetching) n_state = (m_pend == 0) ? 0 : 2;
        end else begin
          n_ppage = m_dpage; n_col = 0; n_dvalid = 0;
          if (m_pend == 1) begin
            n_fetching = 1; n_fcnt = FC - 1; n_fpage = m_target; n_state = 3;
          end else n_state = 4;
        end
      end
      m_state = n_state; m_fcnt = n_fcnt; m_fpage = n_fpage; m_dpage = n_dpage;
      m_ppage = n_ppage; m_col = n_col; m_pend = n_pend; m_target = n_target;
      m_fetching = n_fetching; m_dvalid = n_dvalid; m_err = n_err;
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_rdy, exp_d;
      exp_rdy = (m_state == 0 || m_state == 3 || m_state == 4) ? 1 : 0;
      exp_d = (m_ppage >= 0 && m_col < PB) ? abyte(m_ppage, m_col) : 8'hFF;
      chk(ready == exp_rdy[0], "ready", int'(ready), exp_rdy);
      chk(err == m_err, "err", int'(err), int'(m_err));
      chk(int'(rd_data) == exp_d, "rd_data", int'(rd_data), exp_d);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  task automatic issue(logic [7:0] code, bit av, int page);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_addr_valid = av; cmd_page = PBITS'(page);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_addr_valid = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 1000 && !ready; i++) @(negedge clk);
  endtask

  task automatic read_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rd_strobe = 1'b1;
      @(negedge clk); rd_strobe = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic expect_page(int p, string tag);
    // direct check of first byte at the port after a copy
    @(negedge clk);
    chk(int'(rd_data) == abyte(p, 0), {tag, " first byte"}, int'(rd_data), abyte(p, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    @(negedge clk);
    chk(ready && !err && rd_data == 8'hFF, "reset state", int'({ready, err}), 2);

    cur_req = "R2";
    issue(8'h30, 0, 5);
    wait_ready();
    read_n(3);

    cur_req = "R3";
    issue(8'h31, 0, 0);
    wait_ready();
    expect_page(5, "R3");
    cur_req = "R7";
    read_n(PB + 3);

    cur_req = "R4";
    issue(8'h31, 1, 20);
    wait_ready();
    expect_page(6, "R4");
    read_n(4);
    cur_req = "R5";
    issue(8'h31, 0, 0);
    read_n(2);
    wait_ready();
    expect_page(20, "R5");
    cur_req = "R10";
    read_n(PB / 2);

    cur_req = "R6";
    issue(8'h3F, 0, 0);
    wait_ready();
    expect_page(21, "R6");
    read_n(5);
    issue(8'h31, 0, 0);
    issue(8'h3F, 0, 0);
    read_n(2);

    do_reset();
    cur_req = "R8";
    issue(8'h30, 0, LASTP);
    wait_ready();
    issue(8'h31, 0, 0);
    @(negedge clk);
    chk(ready && err, "top page refused", int'({ready, err}), 3);
    issue(8'h31, 1, 0);
    wait_ready();
    expect_page(LASTP, "R8");
    read_n(PB + 1);
    issue(8'h3F, 0, 0);
    wait_ready();
    expect_page(0, "R8");

    do_reset();
    cur_req = "R9";
    issue(8'h30, 0, 3);
    issue(8'h31, 0, 0);
    read_n(3);
    wait_ready();
    do_reset();
    issue(8'h55, 0, 0);
    do_reset();
    issue(8'h31, 0, 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule